// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This unit performs clamping integer arithmetic on word-wide operands for a processor datapath. An opcode chooses the operation: a wrapping signed add that only reports overflow, signed add, subtract and doubling that clamp to the signed limits, unsigned add and subtract that clamp to the unsigned limits, clamping of a signed value to a programmable bit range (signed or unsigned), and the same range clamp applied separately to each signed half of the word.

Every operation that has to clamp, or that overflows, sets one shared sticky saturation flag. The flag stays set until a clear input drops it. The result is registered. It appears one cycle after the request, together with a valid strobe. The opcode decode that selects the operation and the register-file traffic around the unit belong to the surrounding pipeline.

Top module: `sat_arith_unit`

## Requirements
- R1: Opcode 0 (wrapping add) returns a+b modulo 2^32 and sets the flag when the exact signed sum lies outside [-2^31, 2^31-1].
- R2: Opcodes 1 (add) and 2 (subtract, a-b) return the exact signed result. When that result lies outside the signed 32-bit range, they return 0x7FFFFFFF if a is non-negative and 0x80000000 if a is negative, and set the flag.
- R3: Opcode 3 (doubling of a) returns 0x7FFFFFFF with the flag set when a is at least 0x40000000 as a signed value. It returns 0x80000000 with the flag set when a is at most 0xC0000000 as a signed value, which includes 0xC0000000 itself. Otherwise it returns 2a.
- R4: Opcode 4 (unsigned add) returns 0xFFFFFFFF with the flag set when the true sum exceeds 0xFFFFFFFF. Opcode 5 (unsigned subtract, a-b) returns 0 with the flag set when b > a. Both otherwise return the exact result.
- R5: Opcode 6 clamps signed a to the range [-2^w, 2^w-1], where w is the 5-bit sat_w input. It sets the flag when a clamp occurs.
- R6: Opcode 7 clamps signed a to the range [0, 2^w-1] and sets the flag when a clamp occurs.
- R7: Opcodes 8 (signed) and 9 (unsigned) sign-extend bits 15:0 and bits 31:16 of a. Each half is clamped on its own, as in R5 and R6 respectively, and its low 16 bits are written back into the same half. The flag is set if either half clamps.
- R8: Once set, the flag stays set through later operations that do not clamp, until q_clear is asserted.
- R9: When q_clear is high, the flag is 0 after that clock edge, even if an operation in the same cycle would set it.
- R10: A request accepted with in_valid appears on result, with out_valid high, exactly one clock later. When in_valid is low, result holds its value and out_valid is low on the next cycle.
- R11: Opcodes 10 to 15 are reserved. They return 0 and leave the flag unchanged.
- R12: During and after reset, out_valid, result and q_flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| opa | input | 32 | First operand (the value clamped by range operations) |
| opb | input | 32 | Second operand |
| sat_w | input | 5 | Range width w for opcodes 6 to 9 |
| q_clear | input | 1 | Synchronous clear of the saturation flag |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 32 | Registered result |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
The bench crosses every operand pair from a set of boundary values (both signed limits, the doubling thresholds and their neighbours, half-word edges) through all arithmetic opcodes. It also sweeps every range width for the range operations. Each result is compared against exact 64-bit arithmetic. An overflow test that ignored the operand signs would flag same-sign subtraction or clamp mixed-sign addition. A doubling compare off by one would let 0xC0000000 through unflagged. A half-word mode that did not sign-extend each half would clamp 0x8000 as a large positive number. A sequence test checks the flag separately: a non-sticky flag would drop after a clean operation, and a set that beat the clear would leave the flag high after a same-cycle clear. Reserved codes are checked with the flag both high and low, so a reserved code that disturbed the flag would show up.

// File: rtl/sat_arith_pkg.sv
package sat_arith_pkg;

   typedef enum logic [3:0] {
      OP_ADD_WRAP = 4'd0,
      OP_SADD     = 4'd1,
      OP_SSUB     = 4'd2,
      OP_SDBL     = 4'd3,
      OP_UADD     = 4'd4,
      OP_USUB     = 4'd5,
      OP_SCLAMP   = 4'd6,
      OP_UCLAMP   = 4'd7,
      OP_SCLAMP2  = 4'd8,
      OP_UCLAMP2  = 4'd9
   } sat_op_e;

   localparam logic [3:0] OP_FIRST_RSVD = 4'd10;

   typedef enum logic [1:0] {
      SM_WRAP = 2'd0,
      SM_ADD  = 2'd1,
      SM_SUB  = 2'd2,
      SM_DBL  = 2'd3
   } smode_e;

endpackage

// File: rtl/sat_signed_arith.sv
module sat_signed_arith
   import sat_arith_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  smode_e       mode,
   output logic [W-1:0] res,
   output logic         ovf
);

   localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] sum, dif, rail;
   logic         add_ovf, sub_ovf, dbl_hi, dbl_lo;

   always_comb begin
      sum     = a + b;
      dif     = a - b;
      add_ovf = (sum[W-1] ^ a[W-1]) & ~(a[W-1] ^ b[W-1]);
      sub_ovf = (dif[W-1] ^ a[W-1]) &  (a[W-1] ^ b[W-1]);
      rail    = a[W-1] ? NEG_LIM : POS_LIM;
      // at or above +2^(W-2)
      dbl_hi  = ~a[W-1] & a[W-2];
      // at or below -2^(W-2): bit W-2 clear, or exactly -2^(W-2)
      dbl_lo  = a[W-1] & (~a[W-2] | (a[W-3:0] == '0));
      unique case (mode)
         SM_WRAP: begin res = sum;                  ovf = add_ovf; end
         SM_ADD:  begin res = add_ovf ? rail : sum; ovf = add_ovf; end
         SM_SUB:  begin res = sub_ovf ? rail : dif; ovf = sub_ovf; end
         default: begin
            res = dbl_hi ? POS_LIM : (dbl_lo ? NEG_LIM : {a[W-2:0], 1'b0});
            ovf = dbl_hi | dbl_lo;
         end
      endcase
   end

endmodule

// File: rtl/sat_unsigned_arith.sv
module sat_unsigned_arith #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         is_sub,
   output logic [W-1:0] res,
   output logic         ovf
);

   logic [W:0] wide_sum;
   logic [W:0] wide_dif;

   always_comb begin
      wide_sum = {1'b0, a} + {1'b0, b};
      wide_dif = {1'b0, a} - {1'b0, b};
      if (is_sub) begin
         ovf = wide_dif[W];
         res = ovf ? '0 : wide_dif[W-1:0];
      end else begin
         ovf = wide_sum[W];
         res = ovf ? '1 : wide_sum[W-1:0];
      end
   end

endmodule

// File: rtl/sat_range_clamp.sv
module sat_range_clamp #(
   parameter int W     = 32,
   parameter int OUT_W = 32,
   parameter int SH_W  = $clog2(W)
) (
   input  logic [W-1:0]     val,
   input  logic [SH_W-1:0]  shamt,
   input  logic             is_unsigned,
   output logic [OUT_W-1:0] res,
   output logic             ovf
);

   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0]        limit;
   logic signed [W-1:0] top;
   logic [W-1:0]        full;
   logic                s_hi, s_lo, u_over;

   always_comb begin
      limit  = (ONE << shamt) - ONE;
      top    = $signed(val) >>> shamt;
      s_hi   = ~val[W-1] & (top != '0);
      s_lo   =  val[W-1] & (top != '1);
      u_over = ~val[W-1] & (val > limit);
      if (is_unsigned) begin
         full = val[W-1] ? '0 : (u_over ? limit : val);
         ovf  = val[W-1] | u_over;
      end else begin
         full = s_hi ? limit : (s_lo ? ~limit : val);
         ovf  = s_hi | s_lo;
      end
      res = full[OUT_W-1:0];
   end

endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
   import sat_arith_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SH_W   = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [SH_W-1:0]   sat_w,
   input  logic              q_clear,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              q_flag
);

   localparam int HALF_W = DATA_W / 2;
   localparam int N_HALF = 2;

   generate
      if (DATA_W < 8 || (DATA_W % 2) != 0 || (1 << SH_W) != DATA_W) begin : g_bad_cfg
         $error("sat_arith_unit: DATA_W must be a power of two >= 8 matching SH_W");
      end
   endgenerate

   smode_e            smode;
   logic [DATA_W-1:0] s_res, u_res, c_res, d_res, nxt_res;
   logic              s_ovf, u_ovf, c_ovf, nxt_ovf;
   logic [N_HALF-1:0] d_ovf;

   always_comb begin
      unique case (op)
         OP_SADD: smode = SM_ADD;
         OP_SSUB: smode = SM_SUB;
         OP_SDBL: smode = SM_DBL;
         default: smode = SM_WRAP;
      endcase
   end

   sat_signed_arith #(.W(DATA_W)) u_signed (
      .a(opa), .b(opb), .mode(smode), .res(s_res), .ovf(s_ovf)
   );

   sat_unsigned_arith #(.W(DATA_W)) u_unsigned (
      .a(opa), .b(opb), .is_sub(op == OP_USUB), .res(u_res), .ovf(u_ovf)
   );

   sat_range_clamp #(.W(DATA_W), .OUT_W(DATA_W), .SH_W(SH_W)) u_clamp_word (
      .val(opa), .shamt(sat_w), .is_unsigned(op == OP_UCLAMP),
      .res(c_res), .ovf(c_ovf)
   );

   generate
      for (genvar h = 0; h < N_HALF; h++) begin : g_half
         logic [HALF_W-1:0] half_in;
         logic [DATA_W-1:0] half_ext;
         assign half_in  = opa[h*HALF_W +: HALF_W];
         assign half_ext = {{(DATA_W-HALF_W){half_in[HALF_W-1]}}, half_in};
         sat_range_clamp #(.W(DATA_W), .OUT_W(HALF_W), .SH_W(SH_W)) u_clamp_half (
            .val(half_ext), .shamt(sat_w), .is_unsigned(op == OP_UCLAMP2),
            .res(d_res[h*HALF_W +: HALF_W]), .ovf(d_ovf[h])
         );
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_ADD_WRAP, OP_SADD, OP_SSUB, OP_SDBL: begin nxt_res = s_res; nxt_ovf = s_ovf; end
         OP_UADD, OP_USUB:                       begin nxt_res = u_res; nxt_ovf = u_ovf; end
         OP_SCLAMP, OP_UCLAMP:                   begin nxt_res = c_res; nxt_ovf = c_ovf; end
         OP_SCLAMP2, OP_UCLAMP2:                 begin nxt_res = d_res; nxt_ovf = |d_ovf; end
         default:                                begin nxt_res = '0;    nxt_ovf = 1'b0;  end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         q_flag    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= nxt_res;
         if (q_clear)                  q_flag <= 1'b0;
         else if (in_valid && nxt_ovf) q_flag <= 1'b1;
      end
   end

   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (q_flag && !q_clear) |=> q_flag);

   a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      q_clear |=> !q_flag);

   a_r4_uadd_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_UADD) |=> (result >= $past(opa)));

   a_r4_usub_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_USUB) |=> (result <= $past(opa)));

   a_r6_uclamp_range: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_UCLAMP) |=> ((result >> $past(sat_w)) == '0));

   a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && !out_valid));

   a_r11_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op >= OP_FIRST_RSVD && !q_clear) |=>
      (result == '0 && q_flag == $past(q_flag)));

endmodule

// File: tb/tb_sat_arith_unit.sv
`timescale 1ns/1ps
module tb_sat_arith_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  op = '0;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic [4:0]  sat_w = '0;
   logic        q_clear = 1'b0;
   logic        out_valid;
   logic [31:0] result;
   logic        q_flag;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   sat_arith_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opa(opa),
      .opb(opb), .sat_w(sat_w), .q_clear(q_clear), .out_valid(out_valid),
      .result(result), .q_flag(q_flag)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h (op %0d a %08h b %08h w %0d)",
                  req, act, exp, op, opa, opb, sat_w);
      end
   endtask

   function automatic string req_of(input int code);
      case (code)
         0: return "R1";
         1, 2: return "R2";
         3: return "R3";
         4, 5: return "R4";
         6: return "R5";
         7: return "R6";
         8, 9: return "R7";
         default: return "R11";
      endcase
   endfunction

   function automatic void clampv(input longint v, input int w, input bit uns,
                                  output longint r, output bit f);
      longint hi, lo;
      hi = (64'sd1 <<< w) - 1;
      lo = uns ? 64'sd0 : -(64'sd1 <<< w);
      f = 1'b0;
      r = v;
      if (v > hi) begin r = hi; f = 1'b1; end
      else if (v < lo) begin r = lo; f = 1'b1; end
   endfunction

   function automatic void model(input int code, input logic [31:0] a, input logic [31:0] b,
                                 input int w, output logic [31:0] r, output bit f);
      longint sa, sb, ua, ub, t, rr;
      longint smax, smin;
      bit ff;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      ua = longint'(a);
      ub = longint'(b);
      smax = 64'sd2147483647;
      smin = -64'sd2147483648;
      f = 1'b0;
      r = '0;
      case (code)
         0: begin t = sa + sb; r = a + b; f = (t > smax) || (t < smin); end
         1: begin clampv(sa + sb, 31, 1'b0, rr, f); r = rr[31:0]; end
         2: begin clampv(sa - sb, 31, 1'b0, rr, f); r = rr[31:0]; end
         3: begin
            if (sa >= 64'sd1073741824) begin r = 32'h7FFF_FFFF; f = 1'b1; end
            else if (sa <= -64'sd1073741824) begin r = 32'h8000_0000; f = 1'b1; end
            else begin t = sa * 2; r = t[31:0]; end
         end
         4: begin
            t = ua + ub;
            if (t > 64'sd4294967295) begin r = 32'hFFFF_FFFF; f = 1'b1; end
            else r = t[31:0];
         end
         5: begin
            t = ua - ub;
            if (t < 0) begin r = '0; f = 1'b1; end
            else r = t[31:0];
         end
         6, 7: begin clampv(sa, w, code == 7, rr, f); r = rr[31:0]; end
         8, 9: begin
            for (int h = 0; h < 2; h++) begin
               t = longint'($signed(a[h*16 +: 16]));
               clampv(t, w, code == 9, rr, ff);
               r[h*16 +: 16] = rr[15:0];
               f = f | ff;
            end
         end
         default: begin r = '0; f = 1'b0; end
      endcase
   endfunction

   function automatic logic [31:0] corner(input int i);
      case (i)
         0:  return 32'h0000_0000;
         1:  return 32'h0000_0001;
         2:  return 32'h7FFF_FFFF;
         3:  return 32'h8000_0000;
         4:  return 32'hFFFF_FFFF;
         5:  return 32'h4000_0000;
         6:  return 32'h3FFF_FFFF;
         7:  return 32'hC000_0000;
         8:  return 32'hC000_0001;
         9:  return 32'hBFFF_FFFF;
         10: return 32'h0000_7FFF;
         11: return 32'h0000_8000;
         12: return 32'h8000_7FFF;
         13: return 32'h7FFF_8000;
         14: return 32'h1234_5678;
         default: return 32'hFEDC_BA98;
      endcase
   endfunction

   // called at a falling edge; clears the flag, issues one request, checks it
   task automatic run_op(input int code, input logic [31:0] a, input logic [31:0] b, input int w);
      logic [31:0] er;
      bit ef;
      q_clear  = 1'b1;
      in_valid = 1'b0;
      @(negedge clk);
      q_clear  = 1'b0;
      in_valid = 1'b1;
      op    = code[3:0];
      opa   = a;
      opb   = b;
      sat_w = w[4:0];
      model(code, a, b, w, er, ef);
      @(negedge clk);
      in_valid = 1'b0;
      check(req_of(code), result, er);
      check({req_of(code), " flag"}, {31'b0, q_flag}, {31'b0, ef});
      check("R10 out_valid", {31'b0, out_valid}, 32'd1);
   endtask

   task automatic issue(input int code, input logic [31:0] a, input logic [31:0] b,
                        input bit clr);
      in_valid = 1'b1;
      q_clear  = clr;
      op  = code[3:0];
      opa = a;
      opb = b;
      @(negedge clk);
      in_valid = 1'b0;
      q_clear  = 1'b0;
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      check("R12 out_valid", {31'b0, out_valid}, 32'd0);
      check("R12 result", result, 32'd0);
      check("R12 q_flag", {31'b0, q_flag}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 after release", {30'b0, out_valid, q_flag}, 32'd0);

      // arithmetic opcodes over all corner pairs (R1 R2 R3 R4)
      for (int c = 0; c < 6; c++)
         for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
               run_op(c, corner(i), corner(j), 0);

      // range clamps over every width (R5 R6 R7)
      for (int c = 6; c < 10; c++)
         for (int i = 0; i < 16; i++)
            for (int w = 0; w < 32; w++)
               run_op(c, corner(i), 32'h0, w);

      // R8: sticky flag survives a clean operation
      q_clear = 1'b1; @(negedge clk); q_clear = 1'b0;
      issue(1, 32'h7FFF_FFFF, 32'h1, 1'b0);
      check("R8 set", {31'b0, q_flag}, 32'd1);
      issue(1, 32'h1, 32'h1, 1'b0);
      check("R8 result", result, 32'd2);
      check("R8 still set", {31'b0, q_flag}, 32'd1);

      // R11: reserved with flag high
      issue(12, 32'hDEAD_BEEF, 32'h1, 1'b0);
      check("R11 result", result, 32'd0);
      check("R11 flag kept high", {31'b0, q_flag}, 32'd1);

      // R9: clear beats a same-cycle set
      issue(1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1);
      check("R9 flag", {31'b0, q_flag}, 32'd0);
      check("R9 result", result, 32'h7FFF_FFFF);

      // R11: reserved with flag low
      issue(15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      check("R11 result low", result, 32'd0);
      check("R11 flag kept low", {31'b0, q_flag}, 32'd0);

      // R10: idle cycle holds result
      issue(0, 32'h0000_0010, 32'h0000_0020, 1'b0);
      check("R10 result", result, 32'h30);
      opa = 32'h5555_5555;
      op  = 4'd4;
      @(negedge clk);
      check("R10 hold", result, 32'h30);
      check("R10 idle valid", {31'b0, out_valid}, 32'd0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule